// File: doc/BRIEF.md
# PLL Multiplier/Pre-Divider Search Engine

This block is a sequential search engine. It takes a reference clock frequency and a requested per-lane serial data rate, and finds the integer feedback multiplier M and input pre-divider N for a PLL. The chosen pair gives the output frequency closest to the target. All frequencies and rates are unsigned integers in kHz. The target output frequency is half the data rate. A post-VCO divider of 1, 2, 4 or 8 is selected from the target band. Each allowed N is visited in ascending order.

For every N the engine uses one shared shift-subtract divider twice. The first pass computes the rounded multiplier. The second pass computes the frequency that multiplier actually produces. A candidate is kept only when it is inside the multiplier and output-frequency limits and strictly improves on the best error found so far. A start/busy/done handshake frames each search. The results and the valid/error flags stay on the outputs until the next accepted start.

Top module: `pll_mn_search`

## Requirements
- R1: A request with a data rate below 80000 kHz or above 2500000 kHz (both ends inclusive are accepted) ends with error=1 and valid=0.
- R2: A reference frequency outside 2000..64000 kHz (inclusive) ends with error=1 and valid=0.
- R3: The target is floor(rate/2). The post divider D is 8 when target <= 80000, 4 when target <= 160000, 2 when target <= 320000, and 1 otherwise.
- R4: N is searched in ascending order from max(1, ceil(ref/8000)) to min(16, max(1, floor(ref/2000))), and n_out lies in that range.
- R5: For each N, M = floor((target*N*D + floor(ref/2)) / ref). The candidate is dropped when M < 64 or M > 625.
- R6: The achieved frequency is floor(ref*M/(N*D)). The candidate is dropped when it lies outside 40000..1250000 kHz. fout_khz reports this value.
- R7: A candidate replaces the stored best only when |target - achieved| is strictly smaller, so the smallest N wins a tie.
- R8: When no candidate survives, the search ends with error=1 and valid=0.
- R9: A start pulse seen while idle begins a search, and busy stays high until completion. done is a one-cycle pulse, issued in the cycle busy falls, with exactly one of valid and error set. A start pulse during busy is ignored.
- R10: m_out, n_out, fout_khz, valid and error hold their values while idle without start. An accepted start clears valid and error in the next cycle.
- R11: After reset, busy, done, valid and error are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (accepted only when idle) |
| ref_khz | input | FREQ_W | Reference frequency in kHz, sampled at start |
| rate_khz | input | FREQ_W | Per-lane data rate in kHz, sampled at start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| valid | output | 1 | A configuration was found |
| error | output | 1 | Request rejected or no configuration exists |
| m_out | output | M_W | Chosen multiplier M |
| n_out | output | N_W | Chosen pre-divider N |
| fout_khz | output | FREQ_W | Achieved output frequency in kHz |

## Verification
Faults in the internal state show up at the ports at the done pulse after the search. A wrong band decode, N bound, rounding constant or compare direction gives an M, N or achieved frequency that differs from an independent model of the search. A bad loop bound or a stuck state shows as a missing done pulse, or as a done pulse whose cycle count does not fit the number of N values. A flaw in flag handling shows as valid and error set together, or as a result that changes while the block is idle.

// File: rtl/pll_mn_pkg.sv
package pll_mn_pkg;
  localparam int unsigned RATE_LO_KHZ = 80000;
  localparam int unsigned RATE_HI_KHZ = 2500000;
  localparam int unsigned REF_LO_KHZ  = 2000;
  localparam int unsigned REF_HI_KHZ  = 64000;
  localparam int unsigned PFD_LO_KHZ  = 2000;
  localparam int unsigned PFD_HI_KHZ  = 8000;
  localparam int unsigned BAND_KHZ    = 80000;
  localparam int unsigned MULT_LO     = 64;
  localparam int unsigned MULT_HI     = 625;
  localparam int unsigned NDIV_LIMIT  = 16;
  localparam int unsigned FOUT_LO_KHZ = 40000;
  localparam int unsigned FOUT_HI_KHZ = 1250000;

  typedef enum logic [2:0] {
    S_IDLE, S_LOADM, S_WAITM, S_CHKM, S_LOADF, S_WAITF, S_STEP, S_FIN
  } srch_state_e;
endpackage

// File: rtl/pll_mn_prep.sv
module pll_mn_prep import pll_mn_pkg::*; #(
  parameter int unsigned FREQ_W = 22,
  parameter int unsigned N_W    = 5
) (
  input  logic [FREQ_W-1:0] ref_khz,
  input  logic [FREQ_W-1:0] rate_khz,
  output logic              bad_req,
  output logic [FREQ_W-1:0] target_khz,
  output logic [1:0]        div_sh,
  output logic [N_W-1:0]    n_lo,
  output logic [N_W-1:0]    n_hi
);
  logic [31:0]    ref32, rate32, tgt32;
  logic [N_W-1:0] lo_cnt, hi_cnt;

  assign ref32      = 32'(ref_khz);
  assign rate32     = 32'(rate_khz);
  assign target_khz = rate_khz >> 1;
  assign tgt32      = 32'(target_khz);

  assign bad_req = (rate32 < RATE_LO_KHZ) || (rate32 > RATE_HI_KHZ) ||
                   (ref32 < REF_LO_KHZ) || (ref32 > REF_HI_KHZ);

  // Post divider as a shift amount: 8,4,2,1 by target band
  always_comb begin
    if (tgt32 <= BAND_KHZ)          div_sh = 2'd3;
    else if (tgt32 <= 2 * BAND_KHZ) div_sh = 2'd2;
    else if (tgt32 <= 4 * BAND_KHZ) div_sh = 2'd1;
    else                            div_sh = 2'd0;
  end

  // ceil(ref/PFD_HI): count of j >= 0 with j*PFD_HI < ref, capped at limit
  always_comb begin
    lo_cnt = '0;
    for (int unsigned j = 0; j < NDIV_LIMIT; j++)
      if (j * PFD_HI_KHZ < ref32) lo_cnt = lo_cnt + N_W'(1);
    n_lo = (lo_cnt == '0) ? N_W'(1) : lo_cnt;
  end

  // floor(ref/PFD_LO), clamped to 1..limit
  always_comb begin
    hi_cnt = '0;
    for (int unsigned k = 1; k <= NDIV_LIMIT; k++)
      if (k * PFD_LO_KHZ <= ref32) hi_cnt = hi_cnt + N_W'(1);
    n_hi = (hi_cnt == '0) ? N_W'(1) : hi_cnt;
  end
endmodule

// File: rtl/pll_mn_divider.sv
module pll_mn_divider #(
  parameter int unsigned DP_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [DP_W-1:0] numer,
  input  logic [DP_W-1:0] denom,
  output logic            fin,
  output logic [DP_W-1:0] quot
);
  localparam int unsigned CNT_W = $clog2(DP_W + 1);

  logic             run_q, run_d;
  logic             fin_q, fin_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DP_W-1:0]  rem_q, rem_d, quo_q, quo_d, den_q, den_d;
  logic [DP_W:0]    shifted, trial;
  logic             upd_en;

  assign shifted = {rem_q, quo_q[DP_W-1]};
  assign trial   = shifted - {1'b0, den_q};
  assign upd_en  = go || run_q || fin_q;

  always_comb begin
    run_d = run_q;
    fin_d = 1'b0;
    cnt_d = cnt_q;
    rem_d = rem_q;
    quo_d = quo_q;
    den_d = den_q;
    if (go) begin
      run_d = 1'b1;
      cnt_d = CNT_W'(DP_W);
      rem_d = '0;
      quo_d = numer;
      den_d = denom;
    end else if (run_q) begin
      if (!trial[DP_W]) begin
        rem_d = trial[DP_W-1:0];
        quo_d = {quo_q[DP_W-2:0], 1'b1};
      end else begin
        rem_d = shifted[DP_W-1:0];
        quo_d = {quo_q[DP_W-2:0], 1'b0};
      end
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        run_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      fin_q <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
    end else if (upd_en) begin
      run_q <= run_d;
      fin_q <= fin_d;
      cnt_q <= cnt_d;
      rem_q <= rem_d;
      quo_q <= quo_d;
      den_q <= den_d;
    end
  end

  assign fin  = fin_q;
  assign quot = quo_q;
endmodule

// File: rtl/pll_mn_judge.sv
module pll_mn_judge import pll_mn_pkg::*; #(
  parameter int unsigned FREQ_W = 22,
  parameter int unsigned DP_W   = 32
) (
  input  logic [DP_W-1:0]   m_val,
  input  logic [DP_W-1:0]   f_val,
  input  logic [FREQ_W-1:0] target_khz,
  input  logic [DP_W-1:0]   best_err,
  input  logic              have_best,
  output logic              m_ok,
  output logic              better,
  output logic [DP_W-1:0]   err_abs
);
  logic [DP_W-1:0] tgt;
  logic            f_ok;

  assign tgt     = DP_W'(target_khz);
  assign m_ok    = (m_val >= DP_W'(MULT_LO)) && (m_val <= DP_W'(MULT_HI));
  assign f_ok    = (f_val >= DP_W'(FOUT_LO_KHZ)) && (f_val <= DP_W'(FOUT_HI_KHZ));
  assign err_abs = (tgt >= f_val) ? (tgt - f_val) : (f_val - tgt);
  // strict compare keeps the earliest (smallest N) candidate on a tie
  assign better  = f_ok && (!have_best || (err_abs < best_err));
endmodule

// File: rtl/pll_mn_search.sv
module pll_mn_search import pll_mn_pkg::*; #(
  parameter int unsigned FREQ_W = 22,
  parameter int unsigned M_W    = 10,
  parameter int unsigned N_W    = 5,
  parameter int unsigned DP_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] ref_khz,
  input  logic [FREQ_W-1:0] rate_khz,
  output logic              busy,
  output logic              done,
  output logic              valid,
  output logic              error,
  output logic [M_W-1:0]    m_out,
  output logic [N_W-1:0]    n_out,
  output logic [FREQ_W-1:0] fout_khz
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // request decode
  logic              p_bad;
  logic [FREQ_W-1:0] p_target;
  logic [1:0]        p_divsh;
  logic [N_W-1:0]    p_nlo, p_nhi;

  pll_mn_prep #(.FREQ_W(FREQ_W), .N_W(N_W)) prep_i (
    .ref_khz(ref_khz), .rate_khz(rate_khz), .bad_req(p_bad),
    .target_khz(p_target), .div_sh(p_divsh), .n_lo(p_nlo), .n_hi(p_nhi)
  );

  srch_state_e       state_q, state_d;
  logic [FREQ_W-1:0] ref_q, ref_d, target_q, target_d;
  logic [1:0]        divsh_q, divsh_d;
  logic [N_W-1:0]    n_q, n_d, nhi_q, nhi_d;
  logic [DP_W-1:0]   m_q, m_d, berr_q, berr_d;
  logic [M_W-1:0]    bm_q, bm_d;
  logic [N_W-1:0]    bn_q, bn_d;
  logic [FREQ_W-1:0] bf_q, bf_d;
  logic              found_q, found_d;
  logic              done_q, done_d, valid_q, valid_d, error_q, error_d;

  // shared divider
  logic            dv_go, dv_fin;
  logic [DP_W-1:0] dv_num, dv_den, dv_quot;
  logic [DP_W-1:0] m_num, f_num, f_den;

  assign m_num  = ((DP_W'(target_q) * DP_W'(n_q)) << divsh_q) + DP_W'(ref_q >> 1);
  assign f_num  = DP_W'(m_q[M_W-1:0]) * DP_W'(ref_q);
  assign f_den  = DP_W'(n_q) << divsh_q;
  assign dv_go  = (state_q == S_LOADM) || (state_q == S_LOADF);
  assign dv_num = (state_q == S_LOADF) ? f_num : m_num;
  assign dv_den = (state_q == S_LOADF) ? f_den : DP_W'(ref_q);

  pll_mn_divider #(.DP_W(DP_W)) div_i (
    .clk(clk), .rst_n(core_rst_n), .go(dv_go), .numer(dv_num),
    .denom(dv_den), .fin(dv_fin), .quot(dv_quot)
  );

  logic            j_mok, j_better;
  logic [DP_W-1:0] j_err;

  pll_mn_judge #(.FREQ_W(FREQ_W), .DP_W(DP_W)) judge_i (
    .m_val(m_q), .f_val(dv_quot), .target_khz(target_q), .best_err(berr_q),
    .have_best(found_q), .m_ok(j_mok), .better(j_better), .err_abs(j_err)
  );

  always_comb begin
    state_d  = state_q;
    ref_d    = ref_q;
    target_d = target_q;
    divsh_d  = divsh_q;
    n_d      = n_q;
    nhi_d    = nhi_q;
    m_d      = m_q;
    berr_d   = berr_q;
    bm_d     = bm_q;
    bn_d     = bn_q;
    bf_d     = bf_q;
    found_d  = found_q;
    done_d   = 1'b0;
    valid_d  = valid_q;
    error_d  = error_q;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          valid_d  = 1'b0;
          error_d  = 1'b0;
          found_d  = 1'b0;
          berr_d   = '1;
          bm_d     = '0;
          bn_d     = '0;
          bf_d     = '0;
          ref_d    = ref_khz;
          target_d = p_target;
          divsh_d  = p_divsh;
          n_d      = p_nlo;
          nhi_d    = p_nhi;
          state_d  = (p_bad || (p_nlo > p_nhi)) ? S_FIN : S_LOADM;
        end
      end
      S_LOADM: state_d = S_WAITM;
      S_WAITM: begin
        if (dv_fin) begin
          m_d     = dv_quot;
          state_d = S_CHKM;
        end
      end
      S_CHKM:  state_d = j_mok ? S_LOADF : S_STEP;
      S_LOADF: state_d = S_WAITF;
      S_WAITF: begin
        if (dv_fin) begin
          if (j_better) begin
            found_d = 1'b1;
            berr_d  = j_err;
            bm_d    = m_q[M_W-1:0];
            bn_d    = n_q;
            bf_d    = FREQ_W'(dv_quot);
          end
          state_d = S_STEP;
        end
      end
      S_STEP: begin
        if (n_q == nhi_q) begin
          state_d = S_FIN;
        end else begin
          n_d     = n_q + N_W'(1);
          state_d = S_LOADM;
        end
      end
      S_FIN: begin
        done_d  = 1'b1;
        valid_d = found_q;
        error_d = !found_q;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q  <= S_IDLE;
      ref_q    <= '0;
      target_q <= '0;
      divsh_q  <= '0;
      n_q      <= '0;
      nhi_q    <= '0;
      m_q      <= '0;
      berr_q   <= '0;
      bm_q     <= '0;
      bn_q     <= '0;
      bf_q     <= '0;
      found_q  <= 1'b0;
      done_q   <= 1'b0;
      valid_q  <= 1'b0;
      error_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      ref_q    <= ref_d;
      target_q <= target_d;
      divsh_q  <= divsh_d;
      n_q      <= n_d;
      nhi_q    <= nhi_d;
      m_q      <= m_d;
      berr_q   <= berr_d;
      bm_q     <= bm_d;
      bn_q     <= bn_d;
      bf_q     <= bf_d;
      found_q  <= found_d;
      done_q   <= done_d;
      valid_q  <= valid_d;
      error_q  <= error_d;
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign done     = done_q;
  assign valid    = valid_q;
  assign error    = error_q;
  assign m_out    = bm_q;
  assign n_out    = bn_q;
  assign fout_khz = bf_q;
endmodule

// File: rtl/pll_mn_search_chk.sv
module pll_mn_search_chk import pll_mn_pkg::*; #(
  parameter int unsigned FREQ_W = 22,
  parameter int unsigned M_W    = 10,
  parameter int unsigned N_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              valid,
  input logic              error,
  input logic [M_W-1:0]    m_out,
  input logic [N_W-1:0]    n_out,
  input logic [FREQ_W-1:0] fout_khz
);
  assert_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (valid != error));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(valid) && $stable(error) && $stable(m_out) &&
                           $stable(n_out) && $stable(fout_khz)));

  assert_m_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((32'(m_out) >= MULT_LO) && (32'(m_out) <= MULT_HI)));

  assert_f_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((32'(fout_khz) >= FOUT_LO_KHZ) && (32'(fout_khz) <= FOUT_HI_KHZ)));

  assert_n_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((n_out != '0) && (32'(n_out) <= NDIV_LIMIT)));
endmodule

bind pll_mn_search pll_mn_search_chk #(.FREQ_W(FREQ_W), .M_W(M_W), .N_W(N_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .valid(valid), .error(error), .m_out(m_out), .n_out(n_out), .fout_khz(fout_khz)
);

// File: tb/pll_mn_search_tb_top.sv
`timescale 1ns/1ps
module pll_mn_search_tb_top;
  localparam int unsigned FREQ_W = 22;
  localparam int unsigned M_W    = 10;
  localparam int unsigned N_W    = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [FREQ_W-1:0] ref_khz = '0;
  logic [FREQ_W-1:0] rate_khz = '0;
  logic              busy, done, valid, error;
  logic [M_W-1:0]    m_out;
  logic [N_W-1:0]    n_out;
  logic [FREQ_W-1:0] fout_khz;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pll_mn_search #(.FREQ_W(FREQ_W), .M_W(M_W), .N_W(N_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_khz(ref_khz),
    .rate_khz(rate_khz), .busy(busy), .done(done), .valid(valid),
    .error(error), .m_out(m_out), .n_out(n_out), .fout_khz(fout_khz)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // independent model of the search
  function automatic void mdl(input longint fin, input longint rate, output bit e,
                              output longint mm, output longint nn, output longint ff);
    longint t, k, dv, nlo, nhi, cm, cf, d, bd;
    bit found;
    e = 1; mm = 0; nn = 0; ff = 0; found = 0; bd = 0;
    if (rate < 80000 || rate > 2500000 || fin < 2000 || fin > 64000) return;
    t = rate / 2;
    k = (t + 79999) / 80000;
    if (k > 8) k = 8;
    dv = 8 / k;
    nlo = (fin + 7999) / 8000; nhi = fin / 2000;
    if (nlo < 1) nlo = 1; if (nlo > 16) nlo = 16;
    if (nhi < 1) nhi = 1; if (nhi > 16) nhi = 16;
    for (longint n = nlo; n <= nhi; n++) begin
      cm = (t * n * dv + fin / 2) / fin;
      if (cm < 64 || cm > 625) continue;
      cf = (cm * fin) / (n * dv);
      if (cf < 40000 || cf > 1250000) continue;
      d = (t > cf) ? t - cf : cf - t;
      if (!found || d < bd) begin
        found = 1; bd = d; mm = cm; nn = n; ff = cf;
      end
    end
    e = !found;
  endfunction

  logic [M_W-1:0]    got_m;
  logic [N_W-1:0]    got_n;
  logic [FREQ_W-1:0] got_f;
  bit                got_v, got_e, got_done;

  task automatic wait_done();
    got_done = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin got_done = 1; break; end
      @(negedge clk);
    end
    chk(got_done, "R9", "done seen", got_done, 1);
    got_m = m_out; got_n = n_out; got_f = fout_khz; got_v = valid; got_e = error;
    chk(busy == 1'b0, "R9", "busy low at done", busy, 0);
    chk(got_v != got_e, "R9", "one of valid/error", {got_v, got_e}, 1);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single cycle", done, 0);
  endtask

  task automatic issue(input int fin, input int rate);
    @(negedge clk);
    ref_khz = FREQ_W'(fin); rate_khz = FREQ_W'(rate); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_cmp(input int fin, input int rate, input string req);
    bit e; longint mm, nn, ff;
    issue(fin, rate);
    wait_done();
    mdl(fin, rate, e, mm, nn, ff);
    if (e) begin
      chk(got_e == 1'b1, req, $sformatf("error ref=%0d rate=%0d", fin, rate), got_e, 1);
      chk(got_v == 1'b0, req, "valid low on error", got_v, 0);
    end else begin
      chk(got_v == 1'b1, req, $sformatf("valid ref=%0d rate=%0d", fin, rate), got_v, 1);
      chk(longint'(got_m) == mm, req, "M", got_m, mm);
      chk(longint'(got_n) == nn, req, "N", got_n, nn);
      chk(longint'(got_f) == ff, req, "fout", got_f, ff);
    end
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R11", "busy after reset", busy, 0);
    chk(done == 1'b0, "R11", "done after reset", done, 0);
    chk(valid == 1'b0, "R11", "valid after reset", valid, 0);
    chk(error == 1'b0, "R11", "error after reset", error, 0);
  endtask

  task automatic t_tie();
    // ref 8000, rate 800000: N=2,3,4 all exact; smallest N wins
    issue(8000, 800000);
    wait_done();
    chk(got_v == 1'b1, "R7", "tie valid", got_v, 1);
    chk(got_n == N_W'(2), "R7", "tie N", got_n, 2);
    chk(got_m == M_W'(100), "R5", "tie M", got_m, 100);
    chk(got_f == FREQ_W'(400000), "R6", "tie fout", got_f, 400000);
  endtask

  task automatic t_div8();
    // ref 24000, rate 160000: D=8, N starts at 3, M=80, exact 80000
    issue(24000, 160000);
    wait_done();
    chk(got_n == N_W'(3), "R4", "lowest N", got_n, 3);
    chk(got_m == M_W'(80), "R3", "M with D=8", got_m, 80);
    chk(got_f == FREQ_W'(80000), "R3", "fout with D=8", got_f, 80000);
  endtask

  task automatic t_none();
    // ref 7000, rate 80000: every N fails M or fout limits
    issue(7000, 80000);
    wait_done();
    chk(got_e == 1'b1, "R8", "no candidate error", got_e, 1);
    chk(got_v == 1'b0, "R8", "no candidate valid", got_v, 0);
  endtask

  task automatic t_rate_bounds();
    run_cmp(24000, 79999, "R1");
    chk(got_e == 1'b1, "R1", "rate below range", got_e, 1);
    run_cmp(24000, 80000, "R1");
    run_cmp(2000, 2500000, "R1");
    chk(got_v == 1'b1, "R1", "rate at top accepted", got_v, 1);
    run_cmp(2000, 2500001, "R1");
    chk(got_e == 1'b1, "R1", "rate above range", got_e, 1);
  endtask

  task automatic t_ref_bounds();
    run_cmp(1999, 600000, "R2");
    chk(got_e == 1'b1, "R2", "ref below range", got_e, 1);
    run_cmp(2000, 600000, "R2");
    run_cmp(64000, 600000, "R2");
    run_cmp(64001, 600000, "R2");
    chk(got_e == 1'b1, "R2", "ref above range", got_e, 1);
  endtask

  task automatic t_sweep();
    int refs [5]  = '{2000, 7000, 24000, 27000, 64000};
    int rates [8] = '{80000, 150000, 160002, 333333, 640000, 999998, 1500000, 2500000};
    foreach (refs[i])
      foreach (rates[j])
        run_cmp(refs[i], rates[j], "R5_R6");
  endtask

  task automatic t_busy_ignore();
    bit e; longint mm, nn, ff;
    issue(27000, 999998);
    repeat (5) @(negedge clk);
    ref_khz = FREQ_W'(1999); rate_khz = FREQ_W'(5); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    mdl(27000, 999998, e, mm, nn, ff);
    chk(got_v == 1'b1, "R9", "start during busy ignored", got_v, 1);
    chk(longint'(got_m) == mm && longint'(got_n) == nn, "R9",
        "result of first request M", got_m, mm);
  endtask

  task automatic t_hold();
    issue(24000, 1500000);
    wait_done();
    ref_khz = FREQ_W'(3000); rate_khz = FREQ_W'(90000);
    repeat (30) @(negedge clk);
    chk(m_out == got_m && n_out == got_n, "R10", "M/N held", m_out, got_m);
    chk(fout_khz == got_f, "R10", "fout held", fout_khz, got_f);
    chk(valid == 1'b1, "R10", "valid held", valid, 1);
    issue(24000, 70000);
    chk(valid == 1'b0, "R10", "valid cleared by start", valid, 0);
    wait_done();
    chk(got_e == 1'b1, "R10", "new request error", got_e, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_tie();
    t_div8();
    t_none();
    t_rate_bounds();
    t_ref_bounds();
    t_sweep();
    t_busy_ignore();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule